// File: doc/BRIEF.md
# Buffered Two-Rail Avionics Serial Transmitter

This block sends 32-bit or 25-bit words onto an avionics serial bus from an eight-word holding buffer. The host writes each word as two 16-bit halves: one strobe captures the low half and a second strobe stores the high half and commits the word. Writing is allowed only while the transmit enable is low. Once the host raises the enable, the block sends every buffered word, oldest first, with no further host action, until the buffer is empty.

For each word the block can replace the final bit with a parity bit, odd or even. It shifts the word out least significant bit first on two return-to-zero rails, together with a free-running bit clock. It holds at least four null bit times between words. A ready flag tells the host that the buffer has drained and may be refilled. Bit rate, word length, parity sense, parity enable and the external parity-force pin are static inputs. They change only while the transmitter is idle or in reset.

Top module: `a429_tx_buf`

## Requirements
- R1: The buffer holds up to 8 words. A ninth committed write while 8 words are held is dropped, and only the first 8 words are sent.
- R2: `ld_lo` captures `host_data` as word bits 15:0. A later `ld_hi` supplies bits 31:16 and commits the word to the buffer.
- R3: Load strobes have no effect while `tx_en` is 1. No word is added, and nothing extra is sent.
- R4: After reset, `ready` is 1. It goes to 0 in the cycle after an accepted `ld_hi`. It returns to 1 only after the last buffered word has been fully shifted out, at the start of the following null bit time.
- R5: While `tx_en` is 1, all buffered words are sent in write order.
- R6: Consecutive words are separated by at least 4 null bit times, and by exactly 4 when the next word is already waiting. The gap also holds when a new block is loaded and enabled within one bit time of `ready` rising.
- R7: `short_word` = 0 sends 32 bits and `short_word` = 1 sends 25 bits. Word bit 0 is sent first.
- R8: The parity bit is the last bit sent (bit 31, or bit 24 in 25-bit mode). It is computed over all the bits sent before it. With `par_even` = 0, the full word has an odd number of ones. With `par_even` = 1, it has an even number.
- R9: Parity replaces the last bit when `parity_force` = 1, or when `par_en` = 1. With both at 0, the last bit carries the host's data bit.
- R10: A 1 bit drives `rail_a` high, and a 0 bit drives `rail_b` high, in each case for the first half of the bit time only. Null bit times keep both rails low. The two rails are never high together.
- R11: `bit_clk` runs continuously with period 10 input clocks (`rate_lo` = 0) or 80 (`rate_lo` = 1). It is high for exactly the first half of each bit time, and rail pulses occur only while it is high.
- R12: Reset empties the buffer, holds both rails low and sets `ready`. Reset is asserted asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 16 | Host data half-word |
| ld_lo | input | 1 | Load strobe, low half |
| ld_hi | input | 1 | Load strobe, high half; commits the word |
| tx_en | input | 1 | Transmit enable; blocks writes when 1 |
| rate_lo | input | 1 | 1 = clock/80, 0 = clock/10 bit rate |
| short_word | input | 1 | 1 = 25-bit words, 0 = 32-bit words |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| par_en | input | 1 | Parity insertion enable |
| parity_force | input | 1 | External pin; 1 forces parity insertion |
| rail_a | output | 1 | Return-to-zero rail for 1 bits |
| rail_b | output | 1 | Return-to-zero rail for 0 bits |
| bit_clk | output | 1 | Free-running bit clock |
| ready | output | 1 | Buffer drained and ready for a new block |

## Verification
The assertions assume that the load strobes are single-cycle pulses and that the configuration inputs stay constant while a word is being shifted. They also assume that `ready` can fall only because of an `ld_hi`. The stimulus changes `rate_lo` only during reset. It sets the word-length and parity inputs only while `ready` is 1 and `tx_en` is 0, and it drives every strobe for exactly one clock, away from the active edge. The sweep covers all sixteen combinations of word length, parity sense, parity enable and parity force, with three words each.

// File: rtl/a429_pkg.sv
package a429_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned LAST_LONG  = 31;
  localparam int unsigned LAST_SHORT = 24;
  localparam int unsigned IDX_W    = $clog2(WORD_W);

  // Frames a buffered word: masks to the active length and places parity
  // in the final bit position when insertion is requested.
  function automatic logic [WORD_W-1:0] frame_word(
    input logic [WORD_W-1:0] w,
    input logic              short_w,
    input logic              even_p,
    input logic              insert_p
  );
    logic [WORD_W-1:0] body_mask;
    logic [WORD_W-1:0] last_mask;
    logic              p;
    body_mask = '0;
    last_mask = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < (short_w ? LAST_SHORT : LAST_LONG)) body_mask[i] = 1'b1;
      if (i == (short_w ? LAST_SHORT : LAST_LONG)) last_mask[i] = 1'b1;
    end
    p = ^(w & body_mask);
    p = even_p ? p : ~p;
    if (insert_p) frame_word = (w & body_mask) | (p ? last_mask : '0);
    else          frame_word = w & (body_mask | last_mask);
  endfunction
endpackage

// File: rtl/a429_bit_timer.sv
module a429_bit_timer #(
  parameter int unsigned DIV_HI = 10,
  parameter int unsigned DIV_LO = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_lo,
  output logic tick,
  output logic bit_clk
);
  localparam int unsigned MAXDIV = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int unsigned CW     = $clog2(MAXDIV);
  localparam logic [CW-1:0] LIM_HI = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] LIM_LO = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] HLF_HI = CW'(DIV_HI / 2);
  localparam logic [CW-1:0] HLF_LO = CW'(DIV_LO / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim, hlf;

  always_comb begin
    lim   = rate_lo ? LIM_LO : LIM_HI;
    hlf   = rate_lo ? HLF_LO : HLF_HI;
    tick  = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_clk = (cnt_q < hlf);
endmodule

// File: rtl/a429_word_buf.sv
module a429_word_buf #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [a429_pkg::HALF_W-1:0]   host_data,
  input  logic                          ld_lo,
  input  logic                          ld_hi,
  input  logic                          tx_en,
  input  logic                          pop,
  output logic [a429_pkg::WORD_W-1:0]   head,
  output logic                          empty,
  output logic                          wr_ok,
  output logic [$clog2(DEPTH+1)-1:0]    fill
);
  import a429_pkg::*;
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned FW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [FW-1:0] FULL  = FW'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [HALF_W-1:0] lo_q;
  logic [PW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [FW-1:0]     fill_q, fill_d;
  logic              lo_en, do_pop;

  always_comb begin
    lo_en  = ld_lo & ~tx_en;
    wr_ok  = ld_hi & ~tx_en & (fill_q != FULL);
    do_pop = pop & (fill_q != '0);
    wp_d   = wr_ok  ? ((wp_q == PLAST) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d   = do_pop ? ((rp_q == PLAST) ? '0 : rp_q + 1'b1) : rp_q;
    fill_d = fill_q + FW'(wr_ok) - FW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_en) lo_q <= host_data;
    if (wr_ok) mem[wp_q] <= {host_data, lo_q};
  end

  assign head  = mem[rp_q];
  assign empty = (fill_q == '0);
  assign fill  = fill_q;
endmodule

// File: rtl/a429_serializer.sv
module a429_serializer #(
  parameter int unsigned GAP_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        tx_en,
  input  logic                        empty,
  input  logic [a429_pkg::WORD_W-1:0] head,
  input  logic                        short_word,
  input  logic                        par_even,
  input  logic                        par_en,
  input  logic                        parity_force,
  output logic                        pop,
  output logic                        busy,
  output logic                        cur_bit,
  output logic                        done
);
  import a429_pkg::*;
  localparam int unsigned GW = $clog2(GAP_BITS + 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(GAP_BITS);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic              busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    last_d = last_q;
    gap_d  = gap_q;
    busy_d = busy_q;
    pop    = 1'b0;
    done   = 1'b0;
    if (tick) begin
      if (busy_q) begin
        if (idx_q == last_q) begin
          busy_d = 1'b0;
          gap_d  = GW'(1);
          done   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = sh_q >> 1;
        end
      end else if ((gap_q == GAP_FULL) && !empty && tx_en) begin
        pop    = 1'b1;
        busy_d = 1'b1;
        idx_d  = '0;
        last_d = IDX_W'(short_word ? LAST_SHORT : LAST_LONG);
        sh_d   = frame_word(head, short_word, par_even, par_en | parity_force);
      end else if (gap_q != GAP_FULL) begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gap_q  <= GAP_FULL;
      idx_q  <= '0;
      last_q <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      gap_q  <= gap_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      sh_q   <= sh_d;
    end
  end

  assign busy    = busy_q;
  assign cur_bit = sh_q[0];
endmodule

// File: rtl/a429_tx_buf.sv
module a429_tx_buf #(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned DIV_HI   = 10,
  parameter int unsigned DIV_LO   = 80,
  parameter int unsigned GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] host_data,
  input  logic        ld_lo,
  input  logic        ld_hi,
  input  logic        tx_en,
  input  logic        rate_lo,
  input  logic        short_word,
  input  logic        par_even,
  input  logic        par_en,
  input  logic        parity_force,
  output logic        rail_a,
  output logic        rail_b,
  output logic        bit_clk,
  output logic        ready
);
  import a429_pkg::*;
  localparam int unsigned FW = $clog2(DEPTH+1);

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic              tick, pop, busy, cur_bit, done, empty, wr_ok;
  logic [WORD_W-1:0] head;
  logic [FW-1:0]     fill;
  logic              rdy_q, rdy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  a429_bit_timer #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .rate_lo(rate_lo),
    .tick(tick), .bit_clk(bit_clk)
  );

  a429_word_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_int_n), .host_data(host_data),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .tx_en(tx_en), .pop(pop),
    .head(head), .empty(empty), .wr_ok(wr_ok), .fill(fill)
  );

  a429_serializer #(.GAP_BITS(GAP_BITS)) u_ser (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .tx_en(tx_en),
    .empty(empty), .head(head), .short_word(short_word),
    .par_even(par_even), .par_en(par_en), .parity_force(parity_force),
    .pop(pop), .busy(busy), .cur_bit(cur_bit), .done(done)
  );

  always_comb begin
    rdy_d = rdy_q;
    if (done && empty) rdy_d = 1'b1;
    if (wr_ok)         rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdy_q <= 1'b1;
    else            rdy_q <= rdy_d;
  end

  assign ready  = rdy_q;
  assign rail_a = busy &  cur_bit & bit_clk;
  assign rail_b = busy & ~cur_bit & bit_clk;
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rail_a,
  input logic                       rail_b,
  input logic                       bit_clk,
  input logic                       ready,
  input logic                       ld_hi,
  input logic                       tx_en,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  // R10
  rails_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_a && rail_b));

  // R11
  rail_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_a || rail_b) |-> bit_clk);

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  // R3
  en_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && ld_hi) |=> (fill <= $past(fill)));

  // R4
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(ld_hi));

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!rail_a && !rail_b && fill == '0));
endmodule

bind a429_tx_buf a429_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rail_a(rail_a), .rail_b(rail_b),
  .bit_clk(bit_clk), .ready(ready), .ld_hi(ld_hi), .tx_en(tx_en),
  .fill(fill)
);

// File: tb/a429_tx_buf_tb.sv
module a429_tx_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_data = '0;
  logic        ld_lo = 1'b0, ld_hi = 1'b0, tx_en = 1'b0;
  logic        rate_lo = 1'b0, short_word = 1'b0, par_even = 1'b0;
  logic        par_en = 1'b0, parity_force = 1'b0;
  logic        rail_a, rail_b, bit_clk, ready;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a429_tx_buf u_dut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .ld_lo(ld_lo),
    .ld_hi(ld_hi), .tx_en(tx_en), .rate_lo(rate_lo),
    .short_word(short_word), .par_even(par_even), .par_en(par_en),
    .parity_force(parity_force), .rail_a(rail_a), .rail_b(rail_b),
    .bit_clk(bit_clk), .ready(ready)
  );

  // Receiver model
  logic [31:0] rx_words [0:255];
  int          rx_lens  [0:255];
  int          rx_gaps  [0:255];
  int          rx_n = 0;
  int          both_hi = 0;
  int          nb = 0;
  int          nulls = 99;
  logic [31:0] cur = '0;
  logic        prev_bc = 1'b0;

  always @(negedge clk) begin
    if (rail_a && rail_b) both_hi++;
    if (!rst_n) begin
      nb = 0; nulls = 99; prev_bc = 1'b0;
    end else begin
      if (bit_clk && !prev_bc) begin
        if (rail_a || rail_b) begin
          if (nb == 0) begin cur = '0; rx_gaps[rx_n] = nulls; end
          if (nb < 32) cur[nb] = rail_a;
          nb++;
        end else if (nb > 0) begin
          rx_words[rx_n] = cur; rx_lens[rx_n] = nb; rx_n++;
          nb = 0; nulls = 1;
        end else if (nulls < 99) begin
          nulls++;
        end
      end
      prev_bc = bit_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input bit sh,
                                              input bit ev, input bit pe, input bit pf);
    int L;
    longint dm, full;
    int ones;
    bit p;
    L    = sh ? 25 : 32;
    dm   = (64'd1 << (L-1)) - 1;
    full = (64'd1 << L) - 1;
    ones = $countones(longint'(w) & dm);
    p    = ((ones % 2) == 0) ^ ev;
    if (pe || pf) return 32'((longint'(w) & dm) | (longint'(p) << (L-1)));
    return 32'(longint'(w) & full);
  endfunction

  task automatic load_word(input logic [31:0] w);
    @(negedge clk); host_data = w[15:0];  ld_lo = 1'b1;
    @(negedge clk); ld_lo = 1'b0; host_data = w[31:16]; ld_hi = 1'b1;
    @(negedge clk); ld_hi = 1'b0;
  endtask

  task automatic do_reset(input bit lo);
    @(negedge clk); rst_n = 1'b0; rate_lo = lo;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_block(input int div);
    @(negedge clk); tx_en = 1'b1;
    repeat (2) @(negedge clk);
    while (!ready) @(negedge clk);
    tx_en = 1'b0;
    repeat (3*div) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    @(negedge clk);
    while (bit_clk) @(negedge clk);
    while (!bit_clk) @(negedge clk);
    hi = 0; while (bit_clk)  begin hi++; @(negedge clk); end
    lo = 0; while (!bit_clk) begin lo++; @(negedge clk); end
  endtask

  function automatic logic [31:0] pat(input int a, input int k);
    return 32'hA5C3_0F1E ^ (32'(a) * 32'h0101_0101) ^ (32'(k) * 32'h1357_9BDF);
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, base;
    logic [31:0] w [0:8];
    do_reset(1'b0);
    // R12 / R4: reset state
    chk(ready === 1'b1, "R4 reset ready", ready, 1);
    chk(rail_a === 1'b0 && rail_b === 1'b0, "R12 reset rails", {rail_a, rail_b}, 0);
    // R11: HI rate clock shape
    measure(hi, lo);
    chk(hi == 5 && lo == 5, "R11 bit_clk HI", hi*100+lo, 505);

    // R7 R8 R9 R2 R5 R6: configuration sweep
    for (int cfg = 0; cfg < 16; cfg++) begin
      short_word = cfg[0]; par_even = cfg[1]; par_en = cfg[2]; parity_force = cfg[3];
      base = rx_n;
      for (int k = 0; k < 3; k++) begin
        w[k] = pat(cfg, k);
        load_word(w[k]);
        if (k == 0) chk(ready === 1'b0, "R4 ready after load", ready, 0);
      end
      run_block(10);
      chk(rx_n - base == 3, "R5 word count", rx_n - base, 3);
      for (int k = 0; k < 3; k++) begin
        logic [31:0] e;
        e = expect_word(w[k], cfg[0], cfg[1], cfg[2], cfg[3]);
        chk(rx_words[base+k] == e, "R8 R9 R2 word value", rx_words[base+k], e);
        chk(rx_lens[base+k] == (cfg[0] ? 25 : 32), "R7 word length",
            rx_lens[base+k], cfg[0] ? 25 : 32);
        if (k > 0) chk(rx_gaps[base+k] == 4, "R6 gap", rx_gaps[base+k], 4);
      end
    end

    // R3: strobes while enabled are ignored
    short_word = 0; par_even = 0; par_en = 0; parity_force = 0;
    base = rx_n;
    load_word(32'h1111_2222);
    load_word(32'h3333_4444);
    @(negedge clk); tx_en = 1'b1;
    repeat (50) @(negedge clk);
    load_word(32'hDEAD_BEEF);
    while (!ready) @(negedge clk);
    tx_en = 1'b0;
    repeat (30) @(negedge clk);
    chk(rx_n - base == 2, "R3 ignored write count", rx_n - base, 2);
    chk(rx_words[base+1] == 32'h3333_4444, "R3 last word", rx_words[base+1], 32'h3333_4444);

    // R1: nine writes, eight held
    base = rx_n;
    for (int k = 0; k < 9; k++) begin w[k] = pat(77, k); load_word(w[k]); end
    run_block(10);
    chk(rx_n - base == 8, "R1 full drop count", rx_n - base, 8);
    for (int k = 0; k < 8; k++)
      chk(rx_words[base+k] == w[k], "R1 R5 order", rx_words[base+k], w[k]);

    // R6: fast reload right after ready rises
    base = rx_n;
    load_word(32'h0F0F_F0F0);
    @(negedge clk); tx_en = 1'b1;
    repeat (2) @(negedge clk);
    while (!ready) @(negedge clk);
    tx_en = 1'b0;
    load_word(32'h5555_AAAA);
    @(negedge clk); tx_en = 1'b1;
    repeat (2) @(negedge clk);
    while (!ready) @(negedge clk);
    tx_en = 1'b0;
    repeat (30) @(negedge clk);
    chk(rx_n - base == 2, "R6 reload count", rx_n - base, 2);
    chk(rx_gaps[base+1] == 4, "R6 reload gap", rx_gaps[base+1], 4);
    chk(rx_words[base+1] == 32'h5555_AAAA, "R6 reload word", rx_words[base+1], 32'h5555_AAAA);

    // R12: reset discards a pending block
    load_word(32'h7777_7777);
    do_reset(1'b0);
    chk(ready === 1'b1, "R12 ready after reset", ready, 1);
    base = rx_n;
    @(negedge clk); tx_en = 1'b1;
    repeat (60) @(negedge clk);
    tx_en = 1'b0;
    chk(rx_n - base == 0 && nb == 0, "R12 buffer emptied", rx_n - base, 0);

    // R11: LO rate
    do_reset(1'b1);
    measure(hi, lo);
    chk(hi == 40 && lo == 40, "R11 bit_clk LO", hi*100+lo, 4040);
    base = rx_n;
    load_word(32'h8001_2345);
    run_block(80);
    chk(rx_n - base == 1 && rx_words[base] == 32'h8001_2345, "R11 LO word",
        rx_words[base], 32'h8001_2345);

    // R10: never both rails high
    chk(both_hi == 0, "R10 rails exclusive", both_hi, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule